// File: doc/BRIEF.md
# Enable Interpreter and Soft-Start Sequencer

This block decides whether a switching controller may run, and it produces the soft-start reference that the regulation loop follows. The gating inputs are comparator bits: a supply status with separate rising and falling thresholds, a thermal fault, a shutdown request from the hiccup timer and an external pull-down of the soft-start node. The enable input passes through a minimum-width filter. Any high pulse shorter than `MIN_HI` clock cycles is ignored.

After it is filtered, the enable is read in one of two ways. The choice depends on how far the ramp has risen by the time enable drops. If enable falls early, the controller keeps running, and a later valid high pulse turns it off. If enable falls late, the enable is treated as a plain level. While the controller runs, a counter ramp climbs by a fixed step each cycle up to a clamp. The effective reference is the smaller of the ramp and the target reference. Soft start is flagged as complete once the ramp exceeds the target.

Top module: `ss_enable_ctrl`

## Requirements
- R1: Running requires a qualified supply. Supply becomes qualified on a cycle with `vdd_on_i` high. It stays qualified while both comparator bits are low. It loses qualification on a cycle with `vdd_off_i` high. With an unqualified supply, `run_o` stays 0 even when enable is held high.
- R2: An enable high shorter than `MIN_HI` cycles (default 150 = 3 µs at 50 MHz) has no effect on `run_o`. This holds both while stopped and while running in pulse mode.
- R3: The ramp is compared against `PULSE_LVL` (default 300). If a valid enable falls while the ramp is below that level, the controller keeps running with enable low.
- R4: In pulse mode, the next valid enable high stops the controller. While enable stays high afterwards, the controller does not restart. It needs enable to go low and then high again, validly.
- R5: If the ramp reaches `PULSE_LVL` while enable is still high, enable acts as a level. Its falling edge stops the controller and clears the ramp to 0.
- R6: While running, `ss_val_o` rises by `STEP` (default 4) every cycle and saturates at `CLAMP` (default 4000).
- R7: `ss_val_o` is 0 whenever `run_o` is 0. A high `thermal_i`, `hiccup_i` or `ss_pulldown_i` forces `run_o` to 0 and `ss_val_o` to 0 one cycle later.
- R8: Each fault clears the level or pulse classification. Once every fault has cleared, an enable that is still validly high restarts the ramp from zero.
- R9: `ref_eff_o` equals the smaller of `ss_val_o` and `ref_target_i`.
- R10: `ss_done_o` is 1 exactly when `ss_val_o` is greater than `ref_target_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vdd_on_i | input | 1 | Supply above the start threshold |
| vdd_off_i | input | 1 | Supply below the standby threshold |
| thermal_i | input | 1 | Thermal shutdown flag |
| hiccup_i | input | 1 | Shutdown request from the hiccup timer |
| ss_pulldown_i | input | 1 | External pull-down of the soft-start node |
| en_i | input | 1 | Raw enable (asynchronous) |
| ref_target_i | input | SS_W | Target regulation reference |
| run_o | output | 1 | Controller allowed to switch |
| ss_val_o | output | SS_W | Soft-start ramp value |
| ss_done_o | output | 1 | Ramp above target |
| ref_eff_o | output | SS_W | Effective reference: min(ramp, target) |

## Verification
The hardest state to reach is the pulse-mode path. To get there, an enable pulse has to be long enough to pass the width filter but short enough to drop before the ramp reaches the classification level. The gap between those two limits is only about seventy cycles of ramp. The bench uses a 160-cycle enable pulse for this. That pulse clears the 150-cycle filter with a few cycles to spare, and the ramp is still near 30 when it falls. Then, with the controller running and enable low, the bench sends a sub-width glitch, a valid toggle pulse, and an enable held high after the toggle. In each case it checks that the controller neither stops early nor restarts on its own.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_ARMED = 2'd1,
    MODE_PULSE = 2'd2,
    MODE_LEVEL = 2'd3
  } en_mode_e;
endpackage

// File: rtl/en_filter.sv
module en_filter #(
  parameter int MIN_HI = 150
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic valid_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(MIN_HI + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_HI);

  logic          s1_q, s2_q, valid_q;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!s2_q)              cnt_d = '0;
    else if (cnt_q == CMAX) cnt_d = cnt_q;
    else                    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      s1_q    <= en_i;
      s2_q    <= s1_q;
      cnt_q   <= cnt_d;
      valid_q <= valid_o;
    end
  end

  // high only after MIN_HI consecutive synced-high cycles
  assign valid_o = (cnt_q == CMAX);
  assign rise_o  = valid_o & ~valid_q;
  assign fall_o  = ~valid_o & valid_q;
endmodule

// File: rtl/en_mode_fsm.sv
module en_mode_fsm
  import ss_pkg::*;
#(
  parameter int SS_W      = 12,
  parameter int PULSE_LVL = 300
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vdd_on_i,
  input  logic            vdd_off_i,
  input  logic            thermal_i,
  input  logic            hiccup_i,
  input  logic            ss_pulldown_i,
  input  logic            en_valid_i,
  input  logic            en_rise_i,
  input  logic            en_fall_i,
  input  logic [SS_W-1:0] ss_val_i,
  output logic            run_o,
  output logic            run_nxt_o
);
  localparam logic [SS_W-1:0] LVL_V = SS_W'(PULSE_LVL);

  en_mode_e state_q, state_d;
  logic     supply_q, need_low_q, need_low_d, fault, lvl_hit;

  assign fault   = ~supply_q | thermal_i | hiccup_i | ss_pulldown_i;
  assign lvl_hit = (ss_val_i >= LVL_V);

  always_comb begin
    state_d = state_q;
    if (fault) begin
      state_d = MODE_OFF;
    end else begin
      unique case (state_q)
        MODE_OFF:   if (en_valid_i && !need_low_q) state_d = MODE_ARMED;
        MODE_ARMED: begin
          if (en_fall_i)    state_d = lvl_hit ? MODE_OFF : MODE_PULSE;
          else if (lvl_hit) state_d = MODE_LEVEL;
        end
        MODE_PULSE: if (en_rise_i) state_d = MODE_OFF;
        MODE_LEVEL: if (en_fall_i) state_d = MODE_OFF;
        default:    state_d = MODE_OFF;
      endcase
    end
  end

  // after a pulse toggle-off, wait for enable low before re-arming
  always_comb begin
    need_low_d = need_low_q;
    if (fault)                                   need_low_d = 1'b0;
    else if (state_q == MODE_PULSE && en_rise_i) need_low_d = 1'b1;
    else if (!en_valid_i)                        need_low_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= MODE_OFF;
      supply_q   <= 1'b0;
      need_low_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      need_low_q <= need_low_d;
      if (vdd_on_i)       supply_q <= 1'b1;
      else if (vdd_off_i) supply_q <= 1'b0;
    end
  end

  assign run_o     = (state_q != MODE_OFF);
  assign run_nxt_o = (state_d != MODE_OFF);
endmodule

// File: rtl/ss_ramp.sv
module ss_ramp #(
  parameter int SS_W  = 12,
  parameter int STEP  = 4,
  parameter int CLAMP = 4000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_nxt_i,
  input  logic [SS_W-1:0] ref_target_i,
  output logic [SS_W-1:0] ss_val_o,
  output logic            ss_done_o,
  output logic [SS_W-1:0] ref_eff_o
);
  localparam logic [SS_W:0]   STEP_X  = (SS_W+1)'(STEP);
  localparam logic [SS_W:0]   CLAMP_X = (SS_W+1)'(CLAMP);
  localparam logic [SS_W-1:0] CLAMP_V = SS_W'(CLAMP);

  logic [SS_W-1:0] ss_q, ss_d;
  logic [SS_W:0]   sum;

  assign sum = {1'b0, ss_q} + STEP_X;

  always_comb begin
    if (!run_nxt_i)        ss_d = '0;
    else if (sum >= CLAMP_X) ss_d = CLAMP_V;
    else                   ss_d = sum[SS_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ss_q <= '0;
    else         ss_q <= ss_d;
  end

  assign ss_val_o  = ss_q;
  assign ss_done_o = (ss_q > ref_target_i);
  assign ref_eff_o = ss_done_o ? ref_target_i : ss_q;
endmodule

// File: rtl/ss_enable_ctrl.sv
module ss_enable_ctrl #(
  parameter int SS_W      = 12,
  parameter int MIN_HI    = 150,
  parameter int STEP      = 4,
  parameter int CLAMP     = 4000,
  parameter int PULSE_LVL = 300
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vdd_on_i,
  input  logic            vdd_off_i,
  input  logic            thermal_i,
  input  logic            hiccup_i,
  input  logic            ss_pulldown_i,
  input  logic            en_i,
  input  logic [SS_W-1:0] ref_target_i,
  output logic            run_o,
  output logic [SS_W-1:0] ss_val_o,
  output logic            ss_done_o,
  output logic [SS_W-1:0] ref_eff_o
);
  logic en_valid, en_rise, en_fall, run_nxt;

  en_filter #(.MIN_HI(MIN_HI)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .valid_o (en_valid),
    .rise_o  (en_rise),
    .fall_o  (en_fall)
  );

  en_mode_fsm #(.SS_W(SS_W), .PULSE_LVL(PULSE_LVL)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .vdd_on_i      (vdd_on_i),
    .vdd_off_i     (vdd_off_i),
    .thermal_i     (thermal_i),
    .hiccup_i      (hiccup_i),
    .ss_pulldown_i (ss_pulldown_i),
    .en_valid_i    (en_valid),
    .en_rise_i     (en_rise),
    .en_fall_i     (en_fall),
    .ss_val_i      (ss_val_o),
    .run_o         (run_o),
    .run_nxt_o     (run_nxt)
  );

  ss_ramp #(.SS_W(SS_W), .STEP(STEP), .CLAMP(CLAMP)) u_ramp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_nxt_i    (run_nxt),
    .ref_target_i (ref_target_i),
    .ss_val_o     (ss_val_o),
    .ss_done_o    (ss_done_o),
    .ref_eff_o    (ref_eff_o)
  );
endmodule

// File: rtl/ss_enable_chk.sv
module ss_enable_chk #(
  parameter int SS_W  = 12,
  parameter int STEP  = 4,
  parameter int CLAMP = 4000
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            thermal_i,
  input logic            hiccup_i,
  input logic            ss_pulldown_i,
  input logic [SS_W-1:0] ref_target_i,
  input logic            run_o,
  input logic [SS_W-1:0] ss_val_o,
  input logic            ss_done_o,
  input logic [SS_W-1:0] ref_eff_o
);
  localparam logic [SS_W:0] STEP_X  = (SS_W+1)'(STEP);
  localparam logic [SS_W:0] CLAMP_X = (SS_W+1)'(CLAMP);

  AST_IDLE_RAMP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> ss_val_o == '0);  // R7
  AST_RAMP_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, ss_val_o} <= CLAMP_X);  // R6
  AST_RAMP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> (!run_o || {1'b0, ss_val_o} == CLAMP_X ||
               {1'b0, ss_val_o} == {1'b0, $past(ss_val_o)} + STEP_X));  // R6
  AST_FAULT_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thermal_i || hiccup_i || ss_pulldown_i) |=> !run_o);  // R7
  AST_REF_LE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_eff_o <= ref_target_i && ref_eff_o <= ss_val_o);  // R9
  AST_DONE_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_done_o |-> ref_eff_o == ref_target_i);  // R10
endmodule

bind ss_enable_ctrl ss_enable_chk #(.SS_W(SS_W), .STEP(STEP), .CLAMP(CLAMP)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .thermal_i     (thermal_i),
  .hiccup_i      (hiccup_i),
  .ss_pulldown_i (ss_pulldown_i),
  .ref_target_i  (ref_target_i),
  .run_o         (run_o),
  .ss_val_o      (ss_val_o),
  .ss_done_o     (ss_done_o),
  .ref_eff_o     (ref_eff_o)
);

// File: tb/tb_ss_enable_ctrl.sv
`timescale 1ns/1ps
module tb_ss_enable_ctrl;
  localparam int SS_W = 12;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            vdd_on_i = 1'b0, vdd_off_i = 1'b0;
  logic            thermal_i = 1'b0, hiccup_i = 1'b0, ss_pulldown_i = 1'b0;
  logic            en_i = 1'b0;
  logic [SS_W-1:0] ref_target_i = 12'd1000;
  logic            run_o, ss_done_o;
  logic [SS_W-1:0] ss_val_o, ref_eff_o;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  ss_enable_ctrl dut (.*);

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    cyc(5);
    chk(run_o == 1'b0, "R7 reset run", run_o, 0);
    chk(ss_val_o == 0, "R7 reset ramp", ss_val_o, 0);
    rst_ni = 1'b1;
    cyc(2);
  endtask

  task automatic t_supply;
    en_i = 1'b1;
    cyc(300);
    chk(run_o == 1'b0, "R1 no run unqualified", run_o, 0);
    vdd_on_i = 1'b1; cyc(1); vdd_on_i = 1'b0;
    cyc(300);
    chk(run_o == 1'b1, "R1 run between thresholds", run_o, 1);
    vdd_off_i = 1'b1; cyc(1); vdd_off_i = 1'b0;
    cyc(3);
    chk(run_o == 1'b0, "R1 standby run", run_o, 0);
    chk(ss_val_o == 0, "R1 standby ramp", ss_val_o, 0);
    vdd_on_i = 1'b1; cyc(1); vdd_on_i = 1'b0;
    cyc(200);
    chk(run_o == 1'b1, "R8 restart held enable", run_o, 1);
    en_i = 1'b0;
    cyc(8);
    chk(run_o == 1'b0, "R5 level off", run_o, 0);
  endtask

  task automatic t_glitch;
    en_i = 1'b1; cyc(100); en_i = 1'b0;
    cyc(200);
    chk(run_o == 1'b0, "R2 glitch ignored", run_o, 0);
  endtask

  task automatic t_pulse;
    int a, b;
    ref_target_i = 12'd1000;
    en_i = 1'b1; cyc(160); en_i = 1'b0;
    cyc(5);
    chk(run_o == 1'b1, "R3 pulse keeps run", run_o, 1);
    a = ss_val_o; cyc(1); b = ss_val_o;
    chk(b - a == 4, "R6 step", b - a, 4);
    chk(ref_eff_o == ss_val_o, "R9 ref follows ramp", ref_eff_o, ss_val_o);
    chk(ss_done_o == 1'b0, "R10 not done", ss_done_o, 0);
    en_i = 1'b1; cyc(100); en_i = 1'b0;
    cyc(200);
    chk(run_o == 1'b1, "R2 glitch in pulse mode", run_o, 1);
    cyc(1100);
    chk(ss_val_o == 4000, "R6 clamp", ss_val_o, 4000);
    chk(ref_eff_o == 1000, "R9 ref target", ref_eff_o, 1000);
    chk(ss_done_o == 1'b1, "R10 done", ss_done_o, 1);
    ref_target_i = 12'd4095;
    #1;
    chk(ref_eff_o == 4000, "R9 ref clamp", ref_eff_o, 4000);
    chk(ss_done_o == 1'b0, "R10 not done high target", ss_done_o, 0);
    ref_target_i = 12'd1000;
    en_i = 1'b1;
    cyc(160);
    chk(run_o == 1'b0, "R4 toggle off", run_o, 0);
    chk(ss_val_o == 0, "R4 ramp cleared", ss_val_o, 0);
    cyc(300);
    chk(run_o == 1'b0, "R4 no restart held", run_o, 0);
    en_i = 1'b0;
    cyc(10);
    chk(run_o == 1'b0, "R4 off after low", run_o, 0);
  endtask

  task automatic t_level;
    en_i = 1'b1;
    cyc(400);
    chk(run_o == 1'b1, "R5 level run", run_o, 1);
    en_i = 1'b0;
    cyc(6);
    chk(run_o == 1'b0, "R5 fall stops", run_o, 0);
    chk(ss_val_o == 0, "R5 ramp zero", ss_val_o, 0);
  endtask

  task automatic t_fault;
    en_i = 1'b1;
    cyc(200);
    chk(run_o == 1'b1 && ss_val_o < 1000, "R7 soft start active", ss_val_o, 0);
    thermal_i = 1'b1; cyc(2);
    chk(run_o == 1'b0 && ss_val_o == 0, "R7 thermal", ss_val_o, 0);
    cyc(5); thermal_i = 1'b0; cyc(3);
    chk(run_o == 1'b1 && ss_val_o < 50, "R8 restart after thermal", ss_val_o, 12);
    cyc(20);
    hiccup_i = 1'b1; cyc(2);
    chk(run_o == 1'b0 && ss_val_o == 0, "R7 hiccup", ss_val_o, 0);
    hiccup_i = 1'b0; cyc(20);
    ss_pulldown_i = 1'b1; cyc(2);
    chk(run_o == 1'b0 && ss_val_o == 0, "R7 pulldown", ss_val_o, 0);
    ss_pulldown_i = 1'b0; cyc(3);
    chk(run_o == 1'b1, "R8 restart after pulldown", run_o, 1);
    en_i = 1'b0;
    cyc(10);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_supply();
    t_glitch();
    t_pulse();
    t_level();
    t_fault();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule